// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the sequencing half of a microprogrammed control unit. A control address register selects one word of an on-chip microcode ROM. The selected word is held in a control buffer register, and the control-signal field of that word drives the datapath. Each word also carries a sequencing code, a condition-flag load selector and two candidate next addresses. Combinational next-address logic works from the buffered word and the live inputs, and picks the address of the following word from five sources: the incremented address, one of the two stored addresses, a routine start mapped from the opcode, or a fixed entry point.

The instruction-level flow lives in the microprogram. Three words fetch the instruction and then branch to the indirect routine or straight to the opcode routine. Three indirect words resolve the operand address and then dispatch on the opcode. Six opcode routines use the zero, overflow, indirect and conditional-flag branches. Every routine ends by returning to fetch, or by entering the three-word interrupt routine when an interrupt is pending. A single conditional flip-flop can capture the zero or overflow flag in one word, and a later word then uses it to choose between its two next addresses.

Bits [4:0] of the control output form a step field. The microprogram stores each word's own address there, so the datapath (and a bench) can see which step is active.

Top module: `useq_ctrl`

## Requirements
- R1: With rst high at a rising edge, the control address becomes 0 (fetch entry) and the conditional flip-flop clears. The step field ctrl_o[4:0] reads 0 after that edge.
- R2: ctrl_o is registered. After each rising edge it presents the word at the new control address, and its step field equals that address. Words with the sequencing code "next" (addresses 0, 1, 3, 4, 6, 7, 9, 10, 19, 20, 24) advance to address+1.
- R3: The last fetch word (address 2) goes to the indirect entry 3 when ind_bit_i is 1. Otherwise it dispatches on opcode_i.
- R4: Opcode dispatch maps opcodes 0, 1, 2, 3, 4 and 5 to routine starts 9, 12, 13, 16, 19 and 24. Opcodes 6 and 7 dispatch to address 0.
- R5: The indirect routine runs at addresses 3, 4 and 5. Address 5 dispatches on opcode_i whatever the value of ind_bit_i.
- R6: Address 13 branches to 14 when flag_zero_i is 1, else to 15.
- R7: Address 16 branches to 17 when flag_ovf_i is 1, else to 18.
- R8: Address 12 branches to 29 when ind_bit_i is 1, else to 30.
- R9: Address 19 loads the conditional flip-flop from flag_zero_i, and address 24 loads it from flag_ovf_i. Address 21 goes to 22 if the flip-flop is 1, else to 23. Address 25 goes to 26 if it is 1, else to 27. The live flags have no effect at 21 and 25.
- R10: Unconditional jumps go from 26 to 28 and from 8 (the end of the interrupt routine) to 0. The interrupt routine at 6, 7 and 8 ignores irq_pend_i.
- R11: Routine-end words (11, 14, 15, 17, 18, 22, 23, 27, 28, 29, 30) go to the interrupt entry 6 when irq_pend_i is 1, else to fetch entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 3 | Opcode field of the instruction register |
| flag_zero_i | input | 1 | ALU zero flag |
| flag_ovf_i | input | 1 | ALU overflow flag |
| ind_bit_i | input | 1 | Indirect-addressing bit of the instruction |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| ctrl_o | output | 16 | Control-signal field of the current microinstruction; bits [4:0] are the step field |

## Verification
The assertions assume that every input is a known value, synchronous to clk and stable around the rising edge. They also assume that a flag being consulted reflects the datapath in the same cycle, because the next-address logic samples the inputs combinationally at the edge that leaves the current word. The bench respects these assumptions by changing every input only at the falling edge. It draws fresh values every cycle, so unmapped opcodes, set and clear flags, and pending interrupts all reach every branch word. It also applies one reset in the middle of a routine.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

  localparam int UA_W     = 5;
  localparam int CTL_W    = 16;
  localparam int OPC_W    = 3;
  localparam int STROBE_W = CTL_W - UA_W;
  localparam int N_ROUT   = 6;

  // fixed entry points
  localparam int FETCH_ENTRY = 0;
  localparam int IND_ENTRY   = 3;
  localparam int INT_ENTRY   = 6;

  typedef enum logic [3:0] {
    SQ_NEXT   = 4'd0,
    SQ_JUMP   = 4'd1,
    SQ_ZERO   = 4'd2,
    SQ_OVF    = 4'd3,
    SQ_IND    = 4'd4,
    SQ_CFLAG  = 4'd5,
    SQ_DECODE = 4'd6,
    SQ_MAP    = 4'd7,
    SQ_FINISH = 4'd8
  } seq_e;

  typedef enum logic [1:0] {
    CF_HOLD = 2'd0,
    CF_ZERO = 2'd1,
    CF_OVF  = 2'd2,
    CF_KEEP = 2'd3
  } cfsrc_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctrl;
    seq_e             seq;
    cfsrc_e           cfsrc;
    logic [UA_W-1:0]  alt;
    logic [UA_W-1:0]  dest;
  } uword_t;

  function automatic logic [UA_W-1:0] route_start(input int r);
    case (r)
      0:       return UA_W'(9);
      1:       return UA_W'(12);
      2:       return UA_W'(13);
      3:       return UA_W'(16);
      4:       return UA_W'(19);
      5:       return UA_W'(24);
      default: return UA_W'(FETCH_ENTRY);
    endcase
  endfunction

  function automatic uword_t mk(input int a, input seq_e s, input cfsrc_e c,
                                input int dest, input int alt);
    uword_t w;
    logic [STROBE_W-1:0] sb;
    sb = '0;
    sb[a % STROBE_W] = 1'b1;
    w.ctrl  = {sb, UA_W'(a)};
    w.seq   = s;
    w.cfsrc = c;
    w.alt   = UA_W'(alt);
    w.dest  = UA_W'(dest);
    return w;
  endfunction

  function automatic uword_t ucode(input int a);
    case (a)
      0, 1, 3, 4, 6, 7, 9, 10, 20: return mk(a, SQ_NEXT, CF_HOLD, 0, 0);
      2:  return mk(a, SQ_DECODE, CF_HOLD, 0, IND_ENTRY);
      5:  return mk(a, SQ_MAP, CF_HOLD, 0, 0);
      8:  return mk(a, SQ_JUMP, CF_HOLD, FETCH_ENTRY, 0);
      12: return mk(a, SQ_IND, CF_HOLD, 30, 29);
      13: return mk(a, SQ_ZERO, CF_HOLD, 15, 14);
      16: return mk(a, SQ_OVF, CF_HOLD, 18, 17);
      19: return mk(a, SQ_NEXT, CF_ZERO, 0, 0);
      21: return mk(a, SQ_CFLAG, CF_HOLD, 23, 22);
      24: return mk(a, SQ_NEXT, CF_OVF, 0, 0);
      25: return mk(a, SQ_CFLAG, CF_HOLD, 27, 26);
      26: return mk(a, SQ_JUMP, CF_HOLD, 28, 0);
      11, 14, 15, 17, 18, 22, 23, 27, 28, 29, 30:
          return mk(a, SQ_FINISH, CF_HOLD, 0, 0);
      default: return mk(a, SQ_JUMP, CF_HOLD, FETCH_ENTRY, 0);
    endcase
  endfunction

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output uword_t        word_q
);
  localparam int DEPTH = 1 << AW;

  uword_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ucode(i);
  end

  always_ff @(posedge clk) begin
    word_q <= mem[rd_addr];
  end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int OW = OPC_W,
  parameter int NR = N_ROUT
) (
  input  logic [AW-1:0] car,
  input  seq_e          seq,
  input  logic [AW-1:0] dest,
  input  logic [AW-1:0] alt,
  input  logic [OW-1:0] opcode,
  input  logic          zero,
  input  logic          ovf,
  input  logic          ind,
  input  logic          irq,
  input  logic          cf,
  output logic [AW-1:0] nxt
);
  localparam int NOPC = 1 << OW;

  logic [AW-1:0] map_tab [NOPC];
  logic [AW-1:0] mapped;

  // opcode map: mapped routines below NR, the rest fall back to fetch
  for (genvar g = 0; g < NOPC; g++) begin : g_map
    if (g < NR) begin : g_hit
      assign map_tab[g] = AW'(route_start(g));
    end else begin : g_miss
      assign map_tab[g] = AW'(FETCH_ENTRY);
    end
  end

  assign mapped = map_tab[opcode];

  always_comb begin
    case (seq)
      SQ_NEXT:   nxt = car + AW'(1);
      SQ_JUMP:   nxt = dest;
      SQ_ZERO:   nxt = zero ? alt : dest;
      SQ_OVF:    nxt = ovf  ? alt : dest;
      SQ_IND:    nxt = ind  ? alt : dest;
      SQ_CFLAG:  nxt = cf   ? alt : dest;
      SQ_DECODE: nxt = ind  ? alt : mapped;
      SQ_MAP:    nxt = mapped;
      SQ_FINISH: nxt = irq ? AW'(INT_ENTRY) : AW'(FETCH_ENTRY);
      default:   nxt = AW'(FETCH_ENTRY);
    endcase
  end
endmodule

// File: rtl/useq_cflag.sv
`timescale 1ns/1ps
module useq_cflag
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cfsrc_e src,
  input  logic   zero,
  input  logic   ovf,
  output logic   cf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cf_q <= 1'b0;
    end else begin
      case (src)
        CF_ZERO: cf_q <= zero;
        CF_OVF:  cf_q <= ovf;
        default: cf_q <= cf_q;
      endcase
    end
  end
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int CW = CTL_W,
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode_i,
  input  logic          flag_zero_i,
  input  logic          flag_ovf_i,
  input  logic          ind_bit_i,
  input  logic          irq_pend_i,
  output logic [CW-1:0] ctrl_o
);
  logic [AW-1:0] car_q;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] rd_addr;
  uword_t        word_q;
  logic          cf_q;

  // ROM is read at the address the register is about to take
  assign rd_addr = rst ? AW'(FETCH_ENTRY) : nxt_addr;

  always_ff @(posedge clk) begin
    if (rst) car_q <= AW'(FETCH_ENTRY);
    else     car_q <= nxt_addr;
  end

  useq_rom #(.AW(AW)) u_rom (
    .clk    (clk),
    .rd_addr(rd_addr),
    .word_q (word_q)
  );

  useq_next #(.AW(AW), .OW(OW), .NR(N_ROUT)) u_next (
    .car   (car_q),
    .seq   (word_q.seq),
    .dest  (word_q.dest),
    .alt   (word_q.alt),
    .opcode(opcode_i),
    .zero  (flag_zero_i),
    .ovf   (flag_ovf_i),
    .ind   (ind_bit_i),
    .irq   (irq_pend_i),
    .cf    (cf_q),
    .nxt   (nxt_addr)
  );

  useq_cflag u_cflag (
    .clk (clk),
    .rst (rst),
    .src (word_q.cfsrc),
    .zero(flag_zero_i),
    .ovf (flag_ovf_i),
    .cf_q(cf_q)
  );

  assign ctrl_o = word_q.ctrl;
endmodule

// File: rtl/useq_ctrl_chk.sv
`timescale 1ns/1ps
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             zero,
  input logic             ovf,
  input logic             ind,
  input logic             irq,
  input logic [UA_W-1:0]  car,
  input uword_t           word,
  input logic             cf,
  input logic [UA_W-1:0]  ctrl_tag
);
  // R1
  rst_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (car == UA_W'(FETCH_ENTRY) && !cf));

  // R2
  step_tag_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_tag == car);

  // R2
  next_inc_chk: assert property (@(posedge clk) disable iff (rst)
    word.seq == SQ_NEXT |=> car == UA_W'($past(car) + UA_W'(1)));

  // R3
  decode_ind_chk: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_DECODE && ind) |=> car == UA_W'(IND_ENTRY));

  // R4
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_MAP && int'(opcode) >= N_ROUT) |=> car == UA_W'(FETCH_ENTRY));

  // R9
  cf_zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    word.cfsrc == CF_ZERO |=> cf == $past(zero));

  // R9
  cf_ovf_load_chk: assert property (@(posedge clk) disable iff (rst)
    word.cfsrc == CF_OVF |=> cf == $past(ovf));

  // R11
  finish_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_FINISH && irq) |=> car == UA_W'(INT_ENTRY));

  // R11
  finish_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_FINISH && !irq) |=> car == UA_W'(FETCH_ENTRY));
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .opcode  (opcode_i),
  .zero    (flag_zero_i),
  .ovf     (flag_ovf_i),
  .ind     (ind_bit_i),
  .irq     (irq_pend_i),
  .car     (car_q),
  .word    (word_q),
  .cf      (cf_q),
  .ctrl_tag(ctrl_o[4:0])
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opc = '0;
  logic        z = 1'b0, o = 1'b0, ind = 1'b0, irq = 1'b0;
  logic [15:0] ctrl;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  ma;
  bit  mcf;

  always #2 clk = ~clk;

  useq_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .opcode_i   (opc),
    .flag_zero_i(z),
    .flag_ovf_i (o),
    .ind_bit_i  (ind),
    .irq_pend_i (irq),
    .ctrl_o     (ctrl)
  );

  function automatic int mop(input int op);
    case (op)
      0: return 9;
      1: return 12;
      2: return 13;
      3: return 16;
      4: return 19;
      5: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int mnext(input int a, input int op, input bit fz, input bit fo,
                               input bit fi, input bit fq, input bit c);
    case (a)
      0, 1, 3, 4, 6, 7, 9, 10, 19, 20, 24: return a + 1;
      2:  return fi ? 3 : mop(op);
      5:  return mop(op);
      8:  return 0;
      12: return fi ? 29 : 30;
      13: return fz ? 14 : 15;
      16: return fo ? 17 : 18;
      21: return c ? 22 : 23;
      25: return c ? 26 : 27;
      26: return 28;
      11, 14, 15, 17, 18, 22, 23, 27, 28, 29, 30: return fq ? 6 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string rq(input int a);
    case (a)
      2:  return "R3/R4";
      3, 4, 5: return "R5/R4";
      13: return "R6";
      16: return "R7";
      12: return "R8";
      19, 20, 21, 24, 25: return "R9";
      6, 7, 8, 26: return "R10";
      11, 14, 15, 17, 18, 22, 23, 27, 28, 29, 30: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  initial begin
    int nx;
    bit ncf;
    int prev;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset entry", int'(ctrl[4:0]), 0);
    rst = 1'b0;
    ma  = 0;
    mcf = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) begin
        // R1: reset in the middle of a routine
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid-run reset", int'(ctrl[4:0]), 0);
        rst = 1'b0;
        ma  = 0;
        mcf = 1'b0;
      end
      if (n < 64) begin
        // directed sweep: every opcode with and without indirection
        opc = 3'(n % 8);
        ind = n[3];
        irq = n[4];
        z   = n[0];
        o   = n[1];
      end else begin
        opc = 3'($urandom_range(0, 7));
        ind = 1'($urandom_range(0, 1));
        irq = ($urandom_range(0, 3) == 0);
        z   = 1'($urandom_range(0, 1));
        o   = 1'($urandom_range(0, 1));
      end
      nx   = mnext(ma, int'(opc), z, o, ind, irq, mcf);
      ncf  = (ma == 19) ? z : (ma == 24) ? o : mcf;
      prev = ma;
      @(posedge clk);
      @(negedge clk);
      ma  = nx;
      mcf = ncf;
      chk(rq(prev), int'(ctrl[4:0]), ma);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule